// File: doc/BRIEF.md
# Reference-Counted Instruction Fetch Buffer

This block sits between an in-order fetch stage and an instruction cache. It holds a few recently fetched cache blocks in a small fully associative buffer, and it keeps a separate table of misses that are still outstanding. Every fetch request names an address-space ID and a byte address. Requests that fall in the same block are merged, so each block costs at most one memory read. The block then hands back the instruction word selected by the address offset.

Each buffer entry and each pending entry counts the in-flight instructions that still need it. Buffer entries are kept in recency order, and only an entry whose count is zero may be replaced. The fetch stage talks to the block through three request kinds, at most one of which is served per cycle: a new fetch, a completion, and a squash. A new fetch is answered at once with accept and "fill from buffer" flags. A completion either returns the instruction word or stalls. A squash withdraws one instruction's claim on its block. Memory appears as a read-request port with a ready input and a response port that delivers a whole block.

Top module: `ifetch_merge_buf`

## Requirements
- R1: An entry matches a request only when both the address-space ID and the block address (address divided by block bytes) are equal; the same address under another ID is a different block.
- R2: A new fetch that matches a pending entry is accepted with `req_fill`=1, raises that entry's count and issues no read. This also holds when the occupancy total is at capacity.
- R3: A new fetch that misses the pending table but matches a buffer entry, while pending entries plus nonzero-count buffer entries number fewer than ENTRIES, is accepted with `req_fill`=1 and issues no read.
- R4: A new fetch is refused (`req_ack`=0, no read) when it has no pending match and the occupancy total is ENTRIES or more. Every new fetch is refused while `mem_rd_ready` is low.
- R5: A new fetch that hits nowhere while there is room is accepted with `req_fill`=0. In the same cycle it drives `mem_rd_valid` with `mem_rd_asid` and the block-aligned `mem_rd_addr`, and it opens a pending entry with a count of one.
- R6: A miss completion (`cmp_fill`=0) stalls (`cmp_done`=0) until the response data for its pending entry has arrived. It then returns word number (address mod block bytes)/(WORD_W/8), taken from bits [k*WORD_W +: WORD_W] of the block. It decrements the count and moves the entry into the buffer at the most-recent position.
- R7: A fill completion (`cmp_fill`=1) stalls until its block is in the buffer. It then returns the word as in R6, decrements that entry's count and moves the entry to the most-recent position.
- R8: When a miss completes into a full buffer, the least recently used entry with a zero count is evicted. If no such entry exists, the completion stalls.
- R9: A squash decrements the matching buffer entry, or failing that the matching pending entry. A pending entry that reaches zero is discarded, and data later returned for it is dropped.
- R10: Decrementing a count that is already zero sets the sticky `err_underflow` output; counts saturate at both ends.
- R11: After reset the buffer and the pending table are empty, no read is issued and `err_underflow` is 0.
- R12: One operation is served per cycle. A squash takes priority over a completion, and a completion over a new fetch, so a lower-priority request that meets a higher one is not accepted or completed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New fetch request |
| req_asid | input | ASID_W | Address-space ID of the new fetch |
| req_addr | input | ADDR_W | Byte address of the new fetch |
| req_ack | output | 1 | New fetch accepted this cycle |
| req_fill | output | 1 | Accepted fetch will be filled from the buffer (no own read) |
| cmp_valid | input | 1 | Completion request |
| cmp_fill | input | 1 | 1: fill from buffer, 0: completion of own miss |
| cmp_asid | input | ASID_W | Address-space ID of the completion |
| cmp_addr | input | ADDR_W | Byte address of the completion |
| cmp_done | output | 1 | Completion served this cycle |
| cmp_word | output | WORD_W | Instruction word returned with cmp_done |
| sq_valid | input | 1 | Squash request |
| sq_asid | input | ASID_W | Address-space ID of the squashed fetch |
| sq_addr | input | ADDR_W | Byte address of the squashed fetch |
| mem_rd_ready | input | 1 | Memory port can take a read |
| mem_rd_valid | output | 1 | Block read issued |
| mem_rd_asid | output | ASID_W | Address-space ID of the read |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| mem_rsp_valid | input | 1 | Block data returned |
| mem_rsp_asid | input | ASID_W | Address-space ID of the returned block |
| mem_rsp_blk | input | ADDR_W-log2(WORD_W/8*WORDS) | Block address of the returned block |
| mem_rsp_data | input | WORD_W*WORDS | Returned block, word 0 in the low bits |
| err_underflow | output | 1 | Sticky: a zero count was decremented |

## Verification
The bench builds the block with two buffer entries, four 16-bit words per block, 2-bit IDs, a 12-bit address and 2-bit counts. With only two entries, a full buffer, capacity refusal, a pending merge at capacity and an eviction choice between a busy and an idle entry all come up within a handful of requests. The bench then checks the evictions indirectly: after each one it sees which block misses again and which still hits. Reusing one address under two IDs exercises tag matching, and a squash between a read and its response shows that late data is dropped.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  // Operation served in the current cycle, in descending priority order.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SQUASH,
    OP_CMP_FILL,
    OP_CMP_MISS,
    OP_REQ
  } ifb_op_e;
endpackage

// File: rtl/ifb_pend_tab.sv
module ifb_pend_tab #(
  parameter int P      = 4,
  parameter int ASID_W = 4,
  parameter int BA_W   = 27,
  parameter int BLK_W  = 256,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 2,
  parameter int OCC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [BA_W-1:0]   key_ba,
  output logic              hit,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic              hit_dv,
  output logic [BLK_W-1:0]  hit_data,
  output logic [OCC_W-1:0]  num,
  output logic              free_ok,
  input  logic              cmd_alloc,
  input  logic              cmd_inc,
  input  logic              cmd_dec,
  input  logic              cmd_retire,
  input  logic              rsp_valid,
  input  logic [ASID_W-1:0] rsp_asid,
  input  logic [BA_W-1:0]   rsp_ba,
  input  logic [BLK_W-1:0]  rsp_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              pv_q   [P];
  logic              pdv_q  [P];
  logic [ASID_W-1:0] pasid_q[P];
  logic [BA_W-1:0]   pba_q  [P];
  logic [CNT_W-1:0]  pcnt_q [P];
  logic [BLK_W-1:0]  pdata_q[P];

  logic [IDX_W-1:0] hit_idx, alloc_idx, rsp_idx;
  logic             rsp_hit, drop_now, rsp_write;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    rsp_hit = 1'b0; rsp_idx = '0;
    free_ok = 1'b0; alloc_idx = '0;
    num = '0;
    for (int i = 0; i < P; i++) begin
      if (pv_q[i]) num = num + 1'b1;
      if (pv_q[i] && pasid_q[i] == key_asid && pba_q[i] == key_ba && !hit) begin
        hit = 1'b1; hit_idx = IDX_W'(i);
      end
      if (pv_q[i] && pasid_q[i] == rsp_asid && pba_q[i] == rsp_ba && !rsp_hit) begin
        rsp_hit = 1'b1; rsp_idx = IDX_W'(i);
      end
      if (!pv_q[i] && !free_ok) begin
        free_ok = 1'b1; alloc_idx = IDX_W'(i);
      end
    end
  end

  assign hit_cnt  = pcnt_q[hit_idx];
  assign hit_dv   = pdv_q[hit_idx];
  assign hit_data = pdata_q[hit_idx];

  // Entry leaves the table this cycle: last claim squashed or miss retired.
  assign drop_now  = cmd_retire || (cmd_dec && hit_cnt <= CNT_W'(1));
  assign rsp_write = rsp_valid && rsp_hit && !(drop_now && rsp_idx == hit_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) begin
        pv_q[i] <= 1'b0; pdv_q[i] <= 1'b0;
        pasid_q[i] <= '0; pba_q[i] <= '0; pcnt_q[i] <= '0;
      end
    end else begin
      if (rsp_write) pdv_q[rsp_idx] <= 1'b1;
      if (cmd_alloc) begin
        pv_q[alloc_idx]    <= 1'b1;
        pdv_q[alloc_idx]   <= 1'b0;
        pasid_q[alloc_idx] <= key_asid;
        pba_q[alloc_idx]   <= key_ba;
        pcnt_q[alloc_idx]  <= CNT_W'(1);
      end
      if (cmd_inc && hit_cnt != CNT_MAX) pcnt_q[hit_idx] <= hit_cnt + 1'b1;
      if (cmd_dec && hit_cnt != '0)      pcnt_q[hit_idx] <= hit_cnt - 1'b1;
      if (drop_now) begin
        pv_q[hit_idx]  <= 1'b0;
        pdv_q[hit_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_write) pdata_q[rsp_idx] <= rsp_data;
  end

  // R5
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_alloc |-> (free_ok && !pv_q[alloc_idx]));
  // R9
  squash_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dec && hit_cnt <= CNT_W'(1)) |=> !pv_q[$past(hit_idx)]);
endmodule

// File: rtl/ifb_mru_buf.sv
module ifb_mru_buf #(
  parameter int N      = 4,
  parameter int ASID_W = 4,
  parameter int BA_W   = 27,
  parameter int BLK_W  = 256,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 2,
  parameter int OCC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [BA_W-1:0]   key_ba,
  output logic              hit,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [BLK_W-1:0]  hit_data,
  output logic [OCC_W-1:0]  busy_num,
  output logic              full,
  output logic              victim_ok,
  input  logic              cmd_inc,
  input  logic              cmd_dec,
  input  logic              cmd_use,
  input  logic              cmd_ins,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [BA_W-1:0]   ins_ba,
  input  logic [BLK_W-1:0]  ins_data,
  input  logic [CNT_W-1:0]  ins_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Slots 0..occ_q-1 are live; slot 0 is least recently used.
  logic [ASID_W-1:0] e_asid[N], n_asid[N];
  logic [BA_W-1:0]   e_ba  [N], n_ba  [N];
  logic [CNT_W-1:0]  e_cnt [N], n_cnt [N];
  logic [BLK_W-1:0]  e_data[N], n_data[N];
  logic [OCC_W-1:0]  occ_q, occ_n, tail;

  logic [IDX_W-1:0]  hit_idx, vic_idx, rm_idx;
  logic              do_remove, do_append;
  logic [ASID_W-1:0] app_asid;
  logic [BA_W-1:0]   app_ba;
  logic [CNT_W-1:0]  app_cnt;
  logic [BLK_W-1:0]  app_data;

  function automatic logic [CNT_W-1:0] cnt_up(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    victim_ok = 1'b0; vic_idx = '0;
    busy_num = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(occ_q)) begin
        if (e_cnt[i] != '0) busy_num = busy_num + 1'b1;
        if (e_asid[i] == key_asid && e_ba[i] == key_ba && !hit) begin
          hit = 1'b1; hit_idx = IDX_W'(i);
        end
        if (e_cnt[i] == '0 && !victim_ok) begin
          victim_ok = 1'b1; vic_idx = IDX_W'(i);
        end
      end
    end
  end

  assign full     = (occ_q == OCC_W'(N));
  assign hit_cnt  = e_cnt[hit_idx];
  assign hit_data = e_data[hit_idx];

  assign do_remove = cmd_use || (cmd_ins && full);
  assign do_append = cmd_use || cmd_ins;
  assign rm_idx    = cmd_use ? hit_idx : vic_idx;
  assign tail      = do_remove ? occ_q - 1'b1 : occ_q;
  assign occ_n     = (do_append && !do_remove) ? occ_q + 1'b1 : occ_q;

  always_comb begin
    app_asid = cmd_use ? e_asid[hit_idx] : ins_asid;
    app_ba   = cmd_use ? e_ba[hit_idx]   : ins_ba;
    app_cnt  = cmd_use ? cnt_down(hit_cnt) : ins_cnt;
    app_data = cmd_use ? hit_data : ins_data;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      n_asid[i] = e_asid[i]; n_ba[i] = e_ba[i];
      n_cnt[i]  = e_cnt[i];  n_data[i] = e_data[i];
    end
    if (cmd_inc) n_cnt[hit_idx] = cnt_up(hit_cnt);
    if (cmd_dec) n_cnt[hit_idx] = cnt_down(hit_cnt);
    for (int i = 0; i < N - 1; i++) begin
      if (do_remove && i >= int'(rm_idx)) begin
        n_asid[i] = e_asid[i+1]; n_ba[i] = e_ba[i+1];
        n_cnt[i]  = e_cnt[i+1];  n_data[i] = e_data[i+1];
      end
    end
    if (do_append) begin
      n_asid[IDX_W'(tail)] = app_asid;
      n_ba[IDX_W'(tail)]   = app_ba;
      n_cnt[IDX_W'(tail)]  = app_cnt;
      n_data[IDX_W'(tail)] = app_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < N; i++) begin
        e_asid[i] <= '0; e_ba[i] <= '0; e_cnt[i] <= '0;
      end
    end else begin
      occ_q <= occ_n;
      for (int i = 0; i < N; i++) begin
        e_asid[i] <= n_asid[i]; e_ba[i] <= n_ba[i]; e_cnt[i] <= n_cnt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) e_data[i] <= n_data[i];
  end

  // R8
  full_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ins && full) |-> (victim_ok && do_remove));
  // R7
  use_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_use |=> (occ_q == $past(occ_q)));
endmodule

// File: rtl/ifetch_merge_buf.sv
module ifetch_merge_buf #(
  parameter int ASID_W  = 4,
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 8,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3,
  localparam int INST_BYTES = WORD_W / 8,
  localparam int IB_W   = $clog2(INST_BYTES),
  localparam int OFF_W  = $clog2(INST_BYTES * WORDS),
  localparam int BA_W   = ADDR_W - OFF_W,
  localparam int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ack,
  output logic              req_fill,
  input  logic              cmp_valid,
  input  logic              cmp_fill,
  input  logic [ASID_W-1:0] cmp_asid,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              cmp_done,
  output logic [WORD_W-1:0] cmp_word,
  input  logic              sq_valid,
  input  logic [ASID_W-1:0] sq_asid,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic              mem_rd_ready,
  output logic              mem_rd_valid,
  output logic [ASID_W-1:0] mem_rd_asid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ASID_W-1:0] mem_rsp_asid,
  input  logic [BA_W-1:0]   mem_rsp_blk,
  input  logic [BLK_W-1:0]  mem_rsp_data,
  output logic              err_underflow
);
  import ifb_pkg::*;

  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OCC_W  = $clog2(ENTRIES + 1);
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  function automatic logic [BA_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                  input logic [ADDR_W-1:0] a);
    logic [WIDX_W-1:0] k;
    k = WIDX_W'(a[OFF_W-1:0] >> IB_W);
    return blk[int'(k)*WORD_W +: WORD_W];
  endfunction

  ifb_op_e           op;
  logic [ASID_W-1:0] key_asid;
  logic [ADDR_W-1:0] key_addr;
  logic [BA_W-1:0]   key_ba;

  logic              p_hit, p_dv, p_free;
  logic [CNT_W-1:0]  p_cnt;
  logic [BLK_W-1:0]  p_data;
  logic [OCC_W-1:0]  p_num;
  logic              p_alloc, p_inc, p_dec, p_ret;

  logic              b_hit, b_full, b_vok;
  logic [CNT_W-1:0]  b_cnt, ins_cnt;
  logic [BLK_W-1:0]  b_data;
  logic [OCC_W-1:0]  b_busy;
  logic              b_inc, b_dec, b_use, b_ins;

  logic [OCC_W:0]    occ_total;
  logic              has_room, underflow_ev, err_q;
  logic              unused_lo;

  assign unused_lo = ^{req_addr[OFF_W-1:0], sq_addr[OFF_W-1:0]};

  always_comb begin
    if (sq_valid)       op = OP_SQUASH;
    else if (cmp_valid) op = cmp_fill ? OP_CMP_FILL : OP_CMP_MISS;
    else if (req_valid) op = OP_REQ;
    else                op = OP_IDLE;
    key_asid = sq_valid ? sq_asid : (cmp_valid ? cmp_asid : req_asid);
    key_addr = sq_valid ? sq_addr : (cmp_valid ? cmp_addr : req_addr);
  end
  assign key_ba = blk_of(key_addr);

  ifb_pend_tab #(
    .P(ENTRIES), .ASID_W(ASID_W), .BA_W(BA_W), .BLK_W(BLK_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .key_asid(key_asid), .key_ba(key_ba),
    .hit(p_hit), .hit_cnt(p_cnt), .hit_dv(p_dv), .hit_data(p_data),
    .num(p_num), .free_ok(p_free),
    .cmd_alloc(p_alloc), .cmd_inc(p_inc), .cmd_dec(p_dec), .cmd_retire(p_ret),
    .rsp_valid(mem_rsp_valid), .rsp_asid(mem_rsp_asid), .rsp_ba(mem_rsp_blk),
    .rsp_data(mem_rsp_data)
  );

  ifb_mru_buf #(
    .N(ENTRIES), .ASID_W(ASID_W), .BA_W(BA_W), .BLK_W(BLK_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .OCC_W(OCC_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .key_asid(key_asid), .key_ba(key_ba),
    .hit(b_hit), .hit_cnt(b_cnt), .hit_data(b_data),
    .busy_num(b_busy), .full(b_full), .victim_ok(b_vok),
    .cmd_inc(b_inc), .cmd_dec(b_dec), .cmd_use(b_use), .cmd_ins(b_ins),
    .ins_asid(key_asid), .ins_ba(key_ba), .ins_data(p_data), .ins_cnt(ins_cnt)
  );

  // Occupancy: outstanding misses plus buffer blocks still claimed.
  assign occ_total = {1'b0, p_num} + {1'b0, b_busy};
  assign has_room  = occ_total < (OCC_W+1)'(ENTRIES);

  always_comb begin
    req_ack = 1'b0; req_fill = 1'b0; mem_rd_valid = 1'b0;
    cmp_done = 1'b0; cmp_word = '0;
    p_alloc = 1'b0; p_inc = 1'b0; p_dec = 1'b0; p_ret = 1'b0;
    b_inc = 1'b0; b_dec = 1'b0; b_use = 1'b0; b_ins = 1'b0;
    ins_cnt = '0; underflow_ev = 1'b0;
    unique case (op)
      OP_SQUASH: begin
        if (b_hit) begin
          b_dec = 1'b1; underflow_ev = (b_cnt == '0);
        end else if (p_hit) begin
          p_dec = 1'b1; underflow_ev = (p_cnt == '0);
        end
      end
      OP_CMP_FILL: begin
        if (b_hit) begin
          cmp_done = 1'b1; cmp_word = pick_word(b_data, cmp_addr);
          b_use = 1'b1; underflow_ev = (b_cnt == '0);
        end
      end
      OP_CMP_MISS: begin
        if (p_hit && p_dv && (!b_full || b_vok)) begin
          cmp_done = 1'b1; cmp_word = pick_word(p_data, cmp_addr);
          p_ret = 1'b1; b_ins = 1'b1;
          ins_cnt = (p_cnt == '0) ? '0 : p_cnt - 1'b1;
          underflow_ev = (p_cnt == '0);
        end
      end
      OP_REQ: begin
        if (mem_rd_ready) begin
          if (p_hit) begin
            req_ack = 1'b1; req_fill = 1'b1; p_inc = 1'b1;
          end else if (has_room && b_hit) begin
            req_ack = 1'b1; req_fill = 1'b1; b_inc = 1'b1;
          end else if (has_room && p_free) begin
            req_ack = 1'b1; mem_rd_valid = 1'b1; p_alloc = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign mem_rd_asid = key_asid;
  assign mem_rd_addr = {key_ba, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n)            err_q <= 1'b0;
    else if (underflow_ev) err_q <= 1'b1;
  end
  assign err_underflow = err_q;

  // R12
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ack, cmp_done, sq_valid}));
  // R4
  blocked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_ready);
  // R2
  merge_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_fill) |-> !mem_rd_valid);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
endmodule

// File: tb/sim_ifetch_merge_buf.sv
module sim_ifetch_merge_buf;
  localparam int CLK_P = 10;
  localparam int AW = 2, DW = 12, WW = 16, NW = 4, NE = 2, CW = 2;
  localparam int BW = WW * NW;
  localparam int BAW = DW - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ack, req_fill, cmp_valid, cmp_fill, cmp_done, sq_valid;
  logic mem_rd_ready, mem_rd_valid, mem_rsp_valid, err_underflow;
  logic [AW-1:0] req_asid, cmp_asid, sq_asid, mem_rd_asid, mem_rsp_asid;
  logic [DW-1:0] req_addr, cmp_addr, sq_addr, mem_rd_addr;
  logic [BAW-1:0] mem_rsp_blk;
  logic [BW-1:0] mem_rsp_data;
  logic [WW-1:0] cmp_word;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ifetch_merge_buf #(.ASID_W(AW), .ADDR_W(DW), .WORD_W(WW), .WORDS(NW),
                     .ENTRIES(NE), .CNT_W(CW)) u0 (.*);

  function automatic logic [WW-1:0] mword(int a, int addr);
    return WW'(a * 4096 + (addr >> 3) * 16 + ((addr >> 1) & 3));
  endfunction

  function automatic logic [BW-1:0] mblk(int a, int addr);
    logic [BW-1:0] b;
    for (int i = 0; i < NW; i++) b[i*WW +: WW] = WW'(a * 4096 + (addr >> 3) * 16 + i);
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; cmp_valid = 0; sq_valid = 0; mem_rsp_valid = 0;
    cmp_fill = 0; req_asid = 0; req_addr = 0; cmp_asid = 0; cmp_addr = 0;
    sq_asid = 0; sq_addr = 0; mem_rsp_asid = 0; mem_rsp_blk = 0; mem_rsp_data = 0;
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1; idle(); @(negedge clk);
  endtask

  task automatic do_req(int a, int addr, bit e_ack, bit e_fill, bit e_rd, string tag);
    req_valid = 1; req_asid = AW'(a); req_addr = DW'(addr);
    #1;
    chk(req_ack == e_ack, {tag, " ack"}, req_ack, e_ack);
    if (e_ack) chk(req_fill == e_fill, {tag, " fill"}, req_fill, e_fill);
    chk(mem_rd_valid == e_rd, {tag, " read"}, mem_rd_valid, e_rd);
    if (e_rd) begin
      chk(mem_rd_addr == DW'(addr & ~7), {tag, " read addr"}, mem_rd_addr, addr & ~7);
      chk(mem_rd_asid == AW'(a), {tag, " read id"}, mem_rd_asid, a);
    end
    finish_cycle();
  endtask

  task automatic do_cmp(bit fill, int a, int addr, bit e_done, string tag);
    cmp_valid = 1; cmp_fill = fill; cmp_asid = AW'(a); cmp_addr = DW'(addr);
    #1;
    chk(cmp_done == e_done, {tag, " done"}, cmp_done, e_done);
    if (e_done) chk(cmp_word == mword(a, addr), {tag, " word"}, cmp_word, mword(a, addr));
    finish_cycle();
  endtask

  task automatic do_sq(int a, int addr);
    sq_valid = 1; sq_asid = AW'(a); sq_addr = DW'(addr);
    finish_cycle();
  endtask

  task automatic do_rsp(int a, int addr);
    mem_rsp_valid = 1; mem_rsp_asid = AW'(a); mem_rsp_blk = BAW'(addr >> 3);
    mem_rsp_data = mblk(a, addr);
    finish_cycle();
  endtask

  task automatic t_reset();
    #1;
    chk(mem_rd_valid == 0, "R11 no read after reset", mem_rd_valid, 0);
    chk(err_underflow == 0, "R11 err clear after reset", err_underflow, 0);
    do_cmp(1, 1, 'h104, 0, "R11 empty buffer stalls fill");
  endtask

  task automatic t_miss_merge();
    do_req(1, 'h104, 1, 0, 1, "R5 first miss");
    do_req(1, 'h106, 1, 1, 0, "R2 pending merge");
    do_cmp(1, 1, 'h106, 0, "R7 fill stalls before block in buffer");
    do_cmp(0, 1, 'h104, 0, "R6 miss stalls before data");
    do_rsp(1, 'h100);
    do_cmp(0, 1, 'h104, 1, "R6 miss completes word 2");
    do_cmp(1, 1, 'h106, 1, "R7 fill completes word 3");
  endtask

  task automatic t_asid();
    do_req(2, 'h104, 1, 0, 1, "R1 same address other id misses");
    do_rsp(2, 'h100);
    do_cmp(0, 2, 'h104, 1, "R1 other id word");
  endtask

  task automatic t_capacity_evict();
    do_req(1, 'h102, 1, 1, 0, "R3 buffer hit");
    do_req(2, 'h108, 1, 0, 1, "R5 miss with room");
    do_req(2, 'h100, 0, 0, 0, "R4 buffer hit refused at capacity");
    do_req(2, 'h10A, 1, 1, 0, "R2 pending merge at capacity");
    do_rsp(2, 'h108);
    do_cmp(0, 2, 'h108, 1, "R8 completion evicts idle entry");
    do_cmp(1, 1, 'h102, 1, "R7 fill from kept busy entry");
    do_cmp(1, 2, 'h10A, 1, "R7 fill from new entry");
    do_req(2, 'h100, 1, 0, 1, "R8 evicted block misses again");
    do_rsp(2, 'h100);
    do_cmp(0, 2, 'h100, 1, "R8 completion evicts least recent idle");
    do_req(2, 'h108, 1, 1, 0, "R8 recently used block kept");
    do_req(1, 'h100, 1, 0, 1, "R8 least recent block was evicted");
    do_rsp(1, 'h100);
    do_cmp(0, 1, 'h100, 1, "R6 refill completes");
    do_cmp(1, 2, 'h108, 1, "R7 fill releases claim");
  endtask

  task automatic t_priority();
    mem_rd_ready = 0;
    do_req(1, 'h100, 0, 0, 0, "R4 blocked port refuses hit");
    mem_rd_ready = 1;
    sq_valid = 1; sq_asid = 3; sq_addr = 'h200;
    do_req(1, 'h100, 0, 0, 0, "R12 squash beats request");
    cmp_valid = 1; cmp_fill = 1; cmp_asid = 3; cmp_addr = 'h200;
    do_req(1, 'h100, 0, 0, 0, "R12 completion beats request");
  endtask

  task automatic t_squash();
    do_req(3, 'h200, 1, 0, 1, "R9 miss before squash");
    do_sq(3, 'h200);
    do_rsp(3, 'h200);
    do_req(3, 'h200, 1, 0, 1, "R9 discarded pending entry misses again");
    do_cmp(0, 3, 'h200, 0, "R9 late data was dropped");
    do_rsp(3, 'h200);
    do_cmp(0, 3, 'h200, 1, "R9 fresh data completes");
    do_req(3, 'h204, 1, 1, 0, "R3 hit before squash");
    do_sq(3, 'h204);
    #1 chk(err_underflow == 0, "R10 no error on valid squash", err_underflow, 0);
    do_sq(3, 'h204);
    #1 chk(err_underflow == 1, "R10 second squash underflows", err_underflow, 1);
    do_req(3, 'h300, 1, 0, 1, "R5 miss for shared block");
    do_req(3, 'h302, 1, 1, 0, "R2 merge for shared block");
    do_sq(3, 'h302);
    do_rsp(3, 'h300);
    do_cmp(0, 3, 'h300, 1, "R9 pending entry with claims left survives");
    #1 chk(err_underflow == 1, "R10 error flag sticky", err_underflow, 1);
  endtask

  initial begin
    idle(); mem_rd_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_merge();
    t_asid();
    t_capacity_evict();
    t_priority();
    t_squash();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule